// File: doc/BRIEF.md
# Run-Gated Interrupt Up-Counter

This block is a 16-bit register on the CPU bus that counts CPU cycles and raises an interrupt when it arrives at a terminal value. Software loads the register one byte at a time through two 2 KiB address windows. Bit 15 of the register is a run enable, and bits 14..0 hold the count. While the run bit is set, each cycle that carries the CPU clock enable adds one to the count. When the count reaches all ones (0x7FFF), the pending flag is set, the interrupt line goes high, and counting stops. The count does not wrap.

Any write to either byte of the register acknowledges the interrupt. Software reloads the counter to start the next interval. Both bytes can be read back at any time through a combinational read port, so a handler can see how far the count has gone. The bus is a plain strobe interface with no back-pressure: every write completes in the cycle its strobe is high, and reads never stall.

Top module: `irqc_timer`

## Requirements
- R1: A write with the address in 0x5000–0x57FF (address bits 15..11 = 01010) loads the write byte into register bits 7..0 and leaves bits 15..8 unchanged.
- R2: A write with the address in 0x5800–0x5FFF (address bits 15..11 = 01011) loads the write byte into register bits 15..8 and leaves bits 7..0 unchanged.
- R3: On a clock edge where the enable is high, no write occurs, bit 15 is 1 and bits 14..0 are not 0x7FFF, bits 14..0 increase by one. In every other case without a write, the register keeps its value.
- R4: When an increment makes bits 14..0 equal 0x7FFF, the pending flag is set, and the register then holds its value until it is rewritten.
- R5: Any write to either window clears the pending flag. Loading 0x7FFF into bits 14..0 does not set the flag.
- R6: The interrupt output follows the pending flag and stays high through further enabled cycles until a write acknowledges it.
- R7: A read with the address in the low window returns bits 7..0, one in the high window returns bits 15..8, and one at any other address returns 0.
- R8: Reset (active low) clears the register and the pending flag.
- R9: When a write and an enabled count fall on the same edge, the write sets the result and no increment takes place in that cycle.
- R10: Writes to addresses outside both windows change neither the register nor the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_tick | input | 1 | Enable for one CPU cycle |
| bus_addr | input | 16 | CPU bus address |
| bus_wdata | input | 8 | Write byte |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 8 | Read byte for bus_addr (combinational) |
| irq | output | 1 | Interrupt request, active high |

## Verification
The main sweep loads the high byte with 0xFF and each of the 256 low-byte values, then applies exactly as many enabled cycles as are needed to reach 0x7FFF. This confirms that the interrupt rises on the predicted cycle and not one cycle earlier. It also confirms that the count then freezes, and that a load already at 0x7FFF never fires. Separate patterns cover four cases: a cleared run bit, idle cycles with the enable low, a carry from the low byte into the high byte, and a write coinciding with a count. These show whether the block gates on enable and run, propagates carries, and lets the write take priority. The window edges (0x57FF, 0x5FFF) and addresses just outside them (0x4FFF, 0x6000) check that the decode is exact for both writes and reads.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } irqc_sel_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 11,
  parameter logic [ADDR_W-1:0] LO_BASE = 16'h5000,
  parameter logic [ADDR_W-1:0] HI_BASE = 16'h5800
) (
  input  logic [ADDR_W-1:0] addr,
  output irqc_sel_e         sel
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = {ADDR_W{1'b1}} << WIN_W;

  always_comb begin
    if ((addr & PAGE_MASK) == (LO_BASE & PAGE_MASK))      sel = SEL_LO;
    else if ((addr & PAGE_MASK) == (HI_BASE & PAGE_MASK)) sel = SEL_HI;
    else                                                  sel = SEL_NONE;
  end
endmodule

// File: rtl/irqc_count.sv
module irqc_count
  import irqc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                wr_en,
  input  irqc_sel_e           sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] value,
  output logic                pend
);
  localparam int REG_W = 2 * DATA_W;
  localparam int CNT_W = REG_W - 1;
  localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic             do_wr;
  logic             do_cnt;

  assign run     = value[REG_W-1];
  assign cnt     = value[CNT_W-1:0];
  assign cnt_inc = cnt + CNT_W'(1);
  assign do_wr   = wr_en && (sel != SEL_NONE);
  assign do_cnt  = tick && run && (cnt != TERM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      pend  <= 1'b0;
    end else if (do_wr) begin
      if (sel == SEL_LO) value[DATA_W-1:0]     <= wdata;
      else               value[REG_W-1:DATA_W] <= wdata;
      pend <= 1'b0;
    end else if (do_cnt) begin
      value[CNT_W-1:0] <= cnt_inc;
      if (cnt_inc == TERM) pend <= 1'b1;
    end
  end

  // R3: a stopped counter does not move
  a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_wr && (!tick || !run)) |=> $stable(value));
  // R4: the flag only rises once the terminal value is reached
  a_r4_pend_at_term: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> (cnt == TERM));
  // R4: the count freezes at the terminal value
  a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_wr && cnt == TERM) |=> $stable(value));
  // R5: a write acknowledges
  a_r5_ack: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr |=> !pend);
  // R9: the write takes priority over a count
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && sel == SEL_LO) |=> (value[DATA_W-1:0] == $past(wdata)));
endmodule

// File: rtl/irqc_timer.sv
module irqc_timer
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WIN_W  = 11,
  parameter logic [ADDR_W-1:0] LO_BASE = 16'h5000,
  parameter logic [ADDR_W-1:0] HI_BASE = 16'h5800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int REG_W = 2 * DATA_W;

  irqc_sel_e        sel;
  logic [REG_W-1:0] value;
  logic             pend;

  irqc_decode #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
  ) u_decode (
    .addr(bus_addr),
    .sel (sel)
  );

  irqc_count #(.DATA_W(DATA_W)) u_count (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (cpu_tick),
    .wr_en(bus_we),
    .sel  (sel),
    .wdata(bus_wdata),
    .value(value),
    .pend (pend)
  );

  always_comb begin
    case (sel)
      SEL_LO:  bus_rdata = value[DATA_W-1:0];
      SEL_HI:  bus_rdata = value[REG_W-1:DATA_W];
      default: bus_rdata = '0;
    endcase
  end

  assign irq = pend;

  // R6: the interrupt stays high until a write to a window
  a_r6_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_we && sel != SEL_NONE)) |=> irq);
  // R10: a write outside the windows leaves the register alone
  a_r10_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == SEL_NONE && !cpu_tick) |=> $stable(value));
endmodule

// File: tb/tb_irqc_timer.sv
module tb_irqc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_tick = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wdata = 8'h00;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqc_timer dut (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic tk = 1'b0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; cpu_tick = tk;
    @(negedge clk);
    bus_we = 1'b0; cpu_tick = 1'b0;
  endtask

  task automatic ticks(input int n, input logic en = 1'b1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpu_tick = en;
    end
    @(negedge clk);
    cpu_tick = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    @(negedge clk);
    bus_addr = 16'h5000; #1 v[7:0] = bus_rdata;
    bus_addr = 16'h5800; #1 v[15:8] = bus_rdata;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd16(v);
    check("R8 reset value", v, 16'h0000);
    check("R8 reset irq", irq, 1'b0);

    // R1/R2 edges of the windows
    wr(16'h57FF, 8'h34); wr(16'h5FFF, 8'h12);
    rd16(v);
    check("R1/R2 window edge load", v, 16'h1234);
    // R3 run bit clear, enable high
    ticks(10);
    rd16(v);
    check("R3 run clear holds", v, 16'h1234);
    // R3 carry from low into high byte
    wr(16'h5000, 8'hFE); wr(16'h5800, 8'h80);
    ticks(3);
    rd16(v);
    check("R3 carry count", v, 16'h8101);
    ticks(5, 1'b0);
    rd16(v);
    check("R3 enable low holds", v, 16'h8101);
    // R9 write with a simultaneous count
    wr(16'h5000, 8'h40, 1'b1);
    rd16(v);
    check("R9 write wins", v, 16'h8140);
    wr(16'h5800, 8'h85, 1'b1);
    rd16(v);
    check("R9 write wins high", v, 16'h8540);
    // R10 writes outside
    wr(16'h4FFF, 8'hAA); wr(16'h6000, 8'hBB);
    rd16(v);
    check("R10 outside writes ignored", v, 16'h8540);
    // R7 read outside
    @(negedge clk); bus_addr = 16'h6000; #1;
    check("R7 outside read zero", bus_rdata, 8'h00);
    bus_addr = 16'h4FFF; #1;
    check("R7 below read zero", bus_rdata, 8'h00);

    // R4/R5/R6 sweep over every low byte, terminal at 0x7FFF
    for (int lo = 0; lo < 256; lo++) begin
      int need;
      need = 255 - lo;
      wr(16'h5800, 8'hFF); wr(16'h5000, 8'(lo));
      check("R5 ack after load", irq, 1'b0);
      if (need > 0) begin
        ticks(need - 1);
        check("R4 no early irq", irq, 1'b0);
        ticks(1);
      end
      check("R4 irq at terminal", irq, (need > 0) ? 1'b1 : 1'b0);
      ticks(4);
      rd16(v);
      check("R4 frozen at terminal", v, 16'hFFFF);
      check("R6 irq held", irq, (need > 0) ? 1'b1 : 1'b0);
    end
    wr(16'h4800, 8'h00);
    check("R10 outside write no ack", irq, 1'b0);
    // irq set from last nonzero run? re-arm and test ack via high byte
    wr(16'h5000, 8'hFE);
    ticks(1);
    check("R6 irq raised", irq, 1'b1);
    wr(16'h6000, 8'h00);
    check("R10 outside keeps irq", irq, 1'b1);
    wr(16'h5800, 8'hFF);
    check("R5 high write acks", irq, 1'b0);

    // R8 reset mid-run
    wr(16'h5000, 8'hFE); ticks(1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd16(v);
    check("R8 reset clears value", v, 16'h0000);
    check("R8 reset clears irq", irq, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule